// File: doc/BRIEF.md
# Last-Level Cache Error Reporting Unit

This block collects error events from the ECC checkers of a last-level cache and keeps them where software can find them. Each event is a single-cycle pulse that carries a severity flag, a data-or-tag flag, a 9-bit syndrome, and the location of the faulty access. The location is given as way, requesting agent, operation type, error group, bank and cache-line address. Two optional qualifiers mark a multiple-hit lookup and a dropped eviction of a bad line.

The unit keeps sticky status bits. It records the details of the first error into log registers, and it counts any later errors of the same severity only as a "multiple" flag. It drives a correctable and an uncorrectable interrupt line, each with its own enable.

On early silicon the correctable path of the checker is not trusted for some syndromes. When the early-revision input is high, those events are treated as uncorrectable.

Software reaches the unit through a plain 32-bit word-addressed register port. Writing all ones to the status word forces every status flag on, so that the interrupt wiring can be tested.

Top module: `llc_err_report`

## Requirements
- R1: After reset, the status, control and all three log words read as zero, and both interrupt outputs are low.
- R2: The register map uses word offsets 0x0A for status, 0x0B for control, 0x0C for the main log, 0x0D for the address log and 0x0E for the bank log. Control bits [3:0] are writable and read back. Writes to the log words have no effect.
- R3: An accepted correctable event sets status bits 2 and 0. An accepted uncorrectable event sets status bits 3 and 1. Event flags for multiple hit and dropped eviction set status bits 8 and 6.
- R4: An event that is accepted while status bits 2 and 3 are both clear is logged in full. Status bit 9 records its kind (1 for data, 0 for tag). The main log holds syndrome [31:23], way [22:17], agent [16:13], group [11:8], operation [7:4] and line address bits [41:38] in [3:0], with bit 12 reading zero. The address log holds line address bits [37:6], and the bank log holds the bank in [3:0].
- R5: A correctable event accepted while bit 2 is already set also sets bit 4. An uncorrectable event accepted while bit 3 is already set also sets bit 5. In both cases the three log words and bit 9 keep their values.
- R6: Control bit 0 enables detection of correctable events and bit 1 enables detection of uncorrectable events. An event whose detection bit is clear changes no status or log bit.
- R7: The correctable interrupt is status bit 0 AND control bit 2. The uncorrectable interrupt is status bit 1 AND control bit 3. Clearing an interrupt enable leaves the status bits unchanged.
- R8: Writing zero to the status word clears every status bit and drops both interrupts. Any other value except all ones leaves the status unchanged.
- R9: Writing 0xFFFFFFFF to the status word sets all defined status bits, so status reads 0x37F.
- R10: When the early-revision input is high, a correctable data event is promoted to uncorrectable if its syndrome is one of 0x007, 0x00D, 0x00E, 0x019, 0x01A, 0x01C, 0x041, 0x04E, 0x0B4 or 0x13C. A promoted event is gated by the uncorrectable detection enable.
- R11: When the early-revision input is high, a correctable tag event with syndrome 9 is promoted to uncorrectable. No promotion happens when the input is low, and no promotion happens for other tag syndromes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| early_rev_i | input | 1 | High on first-revision silicon; enables syndrome promotion |
| ev_valid_i | input | 1 | Error event pulse |
| ev_uncorr_i | input | 1 | Event is uncorrectable |
| ev_data_i | input | 1 | Event is in the data array (0: tag array) |
| ev_multihit_i | input | 1 | Event came with a multiple-hit lookup |
| ev_evdrop_i | input | 1 | Event came with a dropped eviction of a bad line |
| ev_syn_i | input | 9 | ECC syndrome |
| ev_way_i | input | 6 | Way of the access |
| ev_agent_i | input | 4 | Requesting agent |
| ev_op_i | input | 4 | Operation type |
| ev_group_i | input | 4 | Error group |
| ev_bank_i | input | 4 | Cache bank |
| ev_line_i | input | 36 | Physical address bits [41:6] |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| irq_corr_o | output | 1 | Correctable error interrupt |
| irq_uncorr_o | output | 1 | Uncorrectable error interrupt |

## Verification
Seen from the ports, the hardest state to reach is one where a promoted event and a detection enable interact. An event that enters as correctable must disappear when only the uncorrectable detection is off, and it must be logged as uncorrectable when only the correctable detection is off. The stimulus table gets there by clearing the status, programming one control pattern, and firing one event per row with early revision and syndrome chosen per row. For the multiple-error flags, the bench first logs a distinctive event and then fires a second event with different fields, so that any overwrite of the log would be visible.

// File: rtl/llc_err_pkg.sv
package llc_err_pkg;

   // register word offsets (software-visible map)
   localparam int OFS_STAT = 10;
   localparam int OFS_CTRL = 11;
   localparam int OFS_LOG  = 12;
   localparam int OFS_ALOG = 13;
   localparam int OFS_BLOG = 14;

   // status bit positions
   localparam int S_CIRQ = 0;
   localparam int S_UIRQ = 1;
   localparam int S_CE   = 2;
   localparam int S_UE   = 3;
   localparam int S_MCE  = 4;
   localparam int S_MUE  = 5;
   localparam int S_EVD  = 6;
   localparam int S_MHIT = 8;
   localparam int S_DATA = 9;
   localparam int STAT_W = 10;
   localparam logic [STAT_W-1:0] STAT_MASK = 10'h37F;

   // control bit positions
   localparam int C_CDET = 0;
   localparam int C_UDET = 1;
   localparam int C_CIE  = 2;
   localparam int C_UIE  = 3;
   localparam int CTRL_W = 4;

   localparam logic [8:0] TAG_BAD_SYN = 9'd9;

   function automatic logic data_syn_untrusted(input logic [8:0] s);
      case (s)
         9'h007, 9'h00D, 9'h00E, 9'h019, 9'h01A,
         9'h01C, 9'h041, 9'h04E, 9'h0B4, 9'h13C: return 1'b1;
         default:                               return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/llc_err_classify.sv
module llc_err_classify
   import llc_err_pkg::*;
#(
   parameter int SYN_W      = 9,
   parameter bit PROMOTE_EN = 1'b1
) (
   input  logic             early_rev_i,
   input  logic             uncorr_i,
   input  logic             data_i,
   input  logic [SYN_W-1:0] syn_i,
   output logic             uc_eff_o
);

   logic promote;

   generate
      if (PROMOTE_EN) begin : g_promote
         if (SYN_W != 9) begin : g_bad_syn
            $error("llc_err_classify: promotion needs a 9-bit syndrome");
         end
         always_comb begin
            promote = 1'b0;
            if (early_rev_i && !uncorr_i) begin
               if (data_i) promote = data_syn_untrusted(syn_i[8:0]);
               else        promote = (syn_i[8:0] == TAG_BAD_SYN);
            end
         end
      end else begin : g_no_promote
         assign promote = 1'b0;
      end
   endgenerate

   assign uc_eff_o = uncorr_i | promote;

endmodule

// File: rtl/llc_err_core.sv
module llc_err_core
   import llc_err_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SYN_W    = 9,
   parameter int WAY_W    = 6,
   parameter int AGT_W    = 4,
   parameter int OP_W     = 4,
   parameter int GRP_W    = 4,
   parameter int BANK_W   = 4,
   parameter int PA_W     = 42,
   parameter int LINE_OFS = 6
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     ev_valid_i,
   input  logic                     ev_uc_i,
   input  logic                     ev_data_i,
   input  logic                     ev_multihit_i,
   input  logic                     ev_evdrop_i,
   input  logic [SYN_W-1:0]         ev_syn_i,
   input  logic [WAY_W-1:0]         ev_way_i,
   input  logic [AGT_W-1:0]         ev_agent_i,
   input  logic [OP_W-1:0]          ev_op_i,
   input  logic [GRP_W-1:0]         ev_group_i,
   input  logic [BANK_W-1:0]        ev_bank_i,
   input  logic [PA_W-1:LINE_OFS]   ev_line_i,
   input  logic                     wr_stat_i,
   input  logic                     wr_ctrl_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [STAT_W-1:0]        stat_o,
   output logic [CTRL_W-1:0]        ctrl_o,
   output logic [DATA_W-1:0]        log_o,
   output logic [DATA_W-1:0]        alog_o,
   output logic [DATA_W-1:0]        blog_o
);

   localparam int PAH_W = PA_W - LINE_OFS - DATA_W;

   logic [STAT_W-1:0] st_q, st_d;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] log_q, alog_q, blog_q;
   logic              accept, first;

   assign accept = ev_valid_i && (ev_uc_i ? ctrl_q[C_UDET] : ctrl_q[C_CDET]);
   assign first  = !(st_q[S_CE] || st_q[S_UE]);

   always_comb begin
      st_d = st_q;
      if (accept) begin
         if (first) st_d[S_DATA] = ev_data_i;
         if (ev_uc_i) begin
            if (st_q[S_UE]) st_d[S_MUE] = 1'b1;
            st_d[S_UE]   = 1'b1;
            st_d[S_UIRQ] = 1'b1;
         end else begin
            if (st_q[S_CE]) st_d[S_MCE] = 1'b1;
            st_d[S_CE]   = 1'b1;
            st_d[S_CIRQ] = 1'b1;
         end
         if (ev_multihit_i) st_d[S_MHIT] = 1'b1;
         if (ev_evdrop_i)   st_d[S_EVD]  = 1'b1;
      end
      if (wr_stat_i) begin
         if (wdata_i == '0)      st_d = '0;
         else if (&wdata_i)      st_d = STAT_MASK;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= '0;
         ctrl_q <= '0;
         log_q  <= '0;
         alog_q <= '0;
         blog_q <= '0;
      end else begin
         st_q <= st_d;
         if (wr_ctrl_i) ctrl_q <= wdata_i[CTRL_W-1:0];
         if (accept && first) begin
            log_q  <= {ev_syn_i, ev_way_i, ev_agent_i, 1'b0, ev_group_i, ev_op_i,
                       ev_line_i[PA_W-1 -: PAH_W]};
            alog_q <= ev_line_i[LINE_OFS+DATA_W-1:LINE_OFS];
            blog_q <= {{(DATA_W-BANK_W){1'b0}}, ev_bank_i};
         end
      end
   end

   assign stat_o = st_q;
   assign ctrl_o = ctrl_q;
   assign log_o  = log_q;
   assign alog_o = alog_q;
   assign blog_o = blog_q;

endmodule

// File: rtl/llc_err_rdmux.sv
module llc_err_rdmux
   import llc_err_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [DATA_W-1:0] log_i,
   input  logic [DATA_W-1:0] alog_i,
   input  logic [DATA_W-1:0] blog_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_LOG  = ADDR_W'(OFS_LOG);
   localparam logic [ADDR_W-1:0] A_ALOG = ADDR_W'(OFS_ALOG);
   localparam logic [ADDR_W-1:0] A_BLOG = ADDR_W'(OFS_BLOG);

   always_comb begin
      case (addr_i)
         A_STAT:  rdata_o = {{(DATA_W-STAT_W){1'b0}}, stat_i};
         A_CTRL:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_i};
         A_LOG:   rdata_o = log_i;
         A_ALOG:  rdata_o = alog_i;
         A_BLOG:  rdata_o = blog_i;
         default: rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/llc_err_report.sv
module llc_err_report
   import llc_err_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int SYN_W      = 9,
   parameter int WAY_W      = 6,
   parameter int AGT_W      = 4,
   parameter int OP_W       = 4,
   parameter int GRP_W      = 4,
   parameter int BANK_W     = 4,
   parameter int PA_W       = 42,
   parameter int LINE_OFS   = 6,
   parameter bit PROMOTE_EN = 1'b1
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   early_rev_i,
   input  logic                   ev_valid_i,
   input  logic                   ev_uncorr_i,
   input  logic                   ev_data_i,
   input  logic                   ev_multihit_i,
   input  logic                   ev_evdrop_i,
   input  logic [SYN_W-1:0]       ev_syn_i,
   input  logic [WAY_W-1:0]       ev_way_i,
   input  logic [AGT_W-1:0]       ev_agent_i,
   input  logic [OP_W-1:0]        ev_op_i,
   input  logic [GRP_W-1:0]       ev_group_i,
   input  logic [BANK_W-1:0]      ev_bank_i,
   input  logic [PA_W-1:LINE_OFS] ev_line_i,
   input  logic                   reg_we_i,
   input  logic [ADDR_W-1:0]      reg_addr_i,
   input  logic [DATA_W-1:0]      reg_wdata_i,
   output logic [DATA_W-1:0]      reg_rdata_o,
   output logic                   irq_corr_o,
   output logic                   irq_uncorr_o
);

   localparam int LOG_BITS = SYN_W + WAY_W + AGT_W + 1 + GRP_W + OP_W + (PA_W - LINE_OFS - DATA_W);

   if (LOG_BITS != DATA_W) begin : g_bad_layout
      $error("llc_err_report: log fields do not fill one register word");
   end
   if (BANK_W > DATA_W || STAT_W > DATA_W) begin : g_bad_width
      $error("llc_err_report: field wider than register word");
   end
   if ((1 << ADDR_W) <= OFS_BLOG) begin : g_bad_addr
      $error("llc_err_report: address too narrow for register map");
   end

   logic              uc_eff;
   logic              wr_stat, wr_ctrl;
   logic [STAT_W-1:0] st_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] log_q, alog_q, blog_q;

   assign wr_stat = reg_we_i && (reg_addr_i == ADDR_W'(OFS_STAT));
   assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CTRL));

   llc_err_classify #(.SYN_W(SYN_W), .PROMOTE_EN(PROMOTE_EN)) classify_i (
      .early_rev_i (early_rev_i),
      .uncorr_i    (ev_uncorr_i),
      .data_i      (ev_data_i),
      .syn_i       (ev_syn_i),
      .uc_eff_o    (uc_eff)
   );

   llc_err_core #(
      .DATA_W(DATA_W), .SYN_W(SYN_W), .WAY_W(WAY_W), .AGT_W(AGT_W), .OP_W(OP_W),
      .GRP_W(GRP_W), .BANK_W(BANK_W), .PA_W(PA_W), .LINE_OFS(LINE_OFS)
   ) core_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .ev_valid_i    (ev_valid_i),
      .ev_uc_i       (uc_eff),
      .ev_data_i     (ev_data_i),
      .ev_multihit_i (ev_multihit_i),
      .ev_evdrop_i   (ev_evdrop_i),
      .ev_syn_i      (ev_syn_i),
      .ev_way_i      (ev_way_i),
      .ev_agent_i    (ev_agent_i),
      .ev_op_i       (ev_op_i),
      .ev_group_i    (ev_group_i),
      .ev_bank_i     (ev_bank_i),
      .ev_line_i     (ev_line_i),
      .wr_stat_i     (wr_stat),
      .wr_ctrl_i     (wr_ctrl),
      .wdata_i       (reg_wdata_i),
      .stat_o        (st_q),
      .ctrl_o        (ctrl_q),
      .log_o         (log_q),
      .alog_o        (alog_q),
      .blog_o        (blog_q)
   );

   llc_err_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rdmux_i (
      .addr_i  (reg_addr_i),
      .stat_i  (st_q),
      .ctrl_i  (ctrl_q),
      .log_i   (log_q),
      .alog_i  (alog_q),
      .blog_i  (blog_q),
      .rdata_o (reg_rdata_o)
   );

   assign irq_corr_o   = st_q[S_CIRQ] & ctrl_q[C_CIE];
   assign irq_uncorr_o = st_q[S_UIRQ] & ctrl_q[C_UIE];

endmodule

// File: rtl/llc_err_report_chk.sv
module llc_err_report_chk
   import llc_err_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              ev_valid_i,
   input logic              ev_uncorr_i,
   input logic              early_rev_i,
   input logic              reg_we_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic              irq_corr_o,
   input logic              irq_uncorr_o,
   input logic [STAT_W-1:0] st_q,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [DATA_W-1:0] log_q
);

   logic stat_wr;
   assign stat_wr = reg_we_i && (reg_addr_i == ADDR_W'(OFS_STAT));

   assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr && reg_wdata_i == '0) |=> (st_q == '0 && !irq_corr_o && !irq_uncorr_o));

   assert_inject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr && (&reg_wdata_i)) |=> (st_q == STAT_MASK));

   assert_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_i && ctrl_q[C_CDET] == 1'b0 && ctrl_q[C_UDET] == 1'b0 && !stat_wr)
      |=> $stable(st_q));

   assert_log_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[S_CE] || st_q[S_UE]) |=> $stable(log_q));

   assert_corr_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_i && !ev_uncorr_i && !early_rev_i && ctrl_q[C_CDET] && !stat_wr)
      |=> (st_q[S_CE] && st_q[S_CIRQ]));

   assert_irq_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[C_CIE] && !ctrl_q[C_UIE]) |-> (!irq_corr_o && !irq_uncorr_o));

endmodule

bind llc_err_report llc_err_report_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ev_valid_i   (ev_valid_i),
   .ev_uncorr_i  (ev_uncorr_i),
   .early_rev_i  (early_rev_i),
   .reg_we_i     (reg_we_i),
   .reg_addr_i   (reg_addr_i),
   .reg_wdata_i  (reg_wdata_i),
   .irq_corr_o   (irq_corr_o),
   .irq_uncorr_o (irq_uncorr_o),
   .st_q         (st_q),
   .ctrl_q       (ctrl_q),
   .log_q        (log_q)
);

// File: tb/llc_err_report_tb_top.sv
`timescale 1ns/1ps
module llc_err_report_tb_top;

   localparam logic [3:0] A_STAT = 4'hA;
   localparam logic [3:0] A_CTRL = 4'hB;
   localparam logic [3:0] A_LOG  = 4'hC;
   localparam logic [3:0] A_ALOG = 4'hD;
   localparam logic [3:0] A_BLOG = 4'hE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        early_rev = 1'b0;
   logic        ev_valid = 1'b0, ev_uncorr = 1'b0, ev_data = 1'b0;
   logic        ev_mhit = 1'b0, ev_evd = 1'b0;
   logic [8:0]  ev_syn = '0;
   logic [5:0]  ev_way = '0;
   logic [3:0]  ev_agent = '0, ev_op = '0, ev_group = '0, ev_bank = '0;
   logic [41:6] ev_line = '0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_c, irq_u;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   llc_err_report dut_i (
      .clk_i(clk), .rst_ni(rst_n), .early_rev_i(early_rev),
      .ev_valid_i(ev_valid), .ev_uncorr_i(ev_uncorr), .ev_data_i(ev_data),
      .ev_multihit_i(ev_mhit), .ev_evdrop_i(ev_evd), .ev_syn_i(ev_syn),
      .ev_way_i(ev_way), .ev_agent_i(ev_agent), .ev_op_i(ev_op),
      .ev_group_i(ev_group), .ev_bank_i(ev_bank), .ev_line_i(ev_line),
      .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .irq_corr_o(irq_c), .irq_uncorr_o(irq_u)
   );

   // row: {ctrl[3:0], early_rev, uncorr, data, syn[8:0], expected status[9:0]}
   localparam int NV = 11;
   localparam logic [25:0] VEC [NV] = '{
      {4'hF, 1'b0, 1'b0, 1'b1, 9'h13C, 10'h205},
      {4'hF, 1'b1, 1'b0, 1'b1, 9'h13C, 10'h20A},
      {4'hF, 1'b1, 1'b0, 1'b0, 9'h009, 10'h00A},
      {4'hF, 1'b1, 1'b0, 1'b0, 9'h13C, 10'h005},
      {4'hF, 1'b1, 1'b0, 1'b1, 9'h009, 10'h205},
      {4'hF, 1'b1, 1'b0, 1'b1, 9'h041, 10'h20A},
      {4'hF, 1'b0, 1'b1, 1'b0, 9'h000, 10'h00A},
      {4'hE, 1'b0, 1'b0, 1'b1, 9'h013, 10'h000},
      {4'hD, 1'b0, 1'b1, 1'b1, 9'h013, 10'h000},
      {4'hD, 1'b1, 1'b0, 1'b1, 9'h0B4, 10'h000},
      {4'hE, 1'b1, 1'b0, 1'b0, 9'h009, 10'h00A}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic fire(input logic uc, input logic dt, input logic [8:0] syn,
                       input logic [5:0] way, input logic [3:0] agt, input logic [3:0] op,
                       input logic [3:0] grp, input logic [3:0] bank, input logic [41:6] line,
                       input logic mh, input logic evd);
      @(negedge clk);
      ev_valid = 1'b1; ev_uncorr = uc; ev_data = dt; ev_syn = syn; ev_way = way;
      ev_agent = agt; ev_op = op; ev_group = grp; ev_bank = bank; ev_line = line;
      ev_mhit = mh; ev_evd = evd;
      @(negedge clk);
      ev_valid = 1'b0; ev_mhit = 1'b0; ev_evd = 1'b0;
   endtask

   function automatic logic [31:0] log_word(input logic [8:0] syn, input logic [5:0] way,
                                            input logic [3:0] agt, input logic [3:0] grp,
                                            input logic [3:0] op, input logic [41:6] line);
      return (32'(syn) << 23) | (32'(way) << 17) | (32'(agt) << 13) |
             (32'(grp) << 8) | (32'(op) << 4) | 32'(line[41:38]);
   endfunction

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] d;
      logic [31:0] exp_log;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_STAT, d); check("R1 status", d, 0);
      rd(A_CTRL, d); check("R1 control", d, 0);
      rd(A_LOG,  d); check("R1 log", d, 0);
      rd(A_ALOG, d); check("R1 addr log", d, 0);
      rd(A_BLOG, d); check("R1 bank log", d, 0);
      check("R1 irqs", {30'd0, irq_c, irq_u}, 0);

      // stimulus table: R3 R6 R10 R11
      for (int i = 0; i < NV; i++) begin
         wr(A_STAT, 32'h0);
         wr(A_CTRL, {28'd0, VEC[i][25:22]});
         early_rev = VEC[i][21];
         fire(VEC[i][20], VEC[i][19], VEC[i][18:10], 6'd1, 4'd1, 4'd1, 4'd1, 4'd1, '0, 1'b0, 1'b0);
         rd(A_STAT, d);
         check($sformatf("R10/R11 row %0d status", i), d, {22'd0, VEC[i][9:0]});
         check($sformatf("R7 row %0d irqs", i), {30'd0, irq_c, irq_u},
               {30'd0, VEC[i][0] & VEC[i][24], VEC[i][1] & VEC[i][25]});
      end
      early_rev = 1'b0;

      // R4 first capture
      wr(A_STAT, 32'h0);
      wr(A_CTRL, 32'hF);
      rd(A_CTRL, d); check("R2 control readback", d, 32'hF);
      fire(1'b0, 1'b0, 9'h155, 6'h2A, 4'h9, 4'h6, 4'hC, 4'hB, 36'hA_1234_5678, 1'b0, 1'b0);
      exp_log = log_word(9'h155, 6'h2A, 4'h9, 4'hC, 4'h6, 36'hA_1234_5678);
      rd(A_STAT, d); check("R3 corr status", d, 32'h005);
      rd(A_LOG,  d); check("R4 log", d, exp_log);
      rd(A_ALOG, d); check("R4 addr log", d, 32'h1234_5678);
      rd(A_BLOG, d); check("R4 bank log", d, 32'hB);

      // R5 later events do not overwrite
      fire(1'b0, 1'b1, 9'h001, 6'h15, 4'h3, 4'h2, 4'h1, 4'h4, 36'h5_8765_4321, 1'b0, 1'b0);
      rd(A_STAT, d); check("R5 multi corr", d, 32'h015);
      rd(A_LOG,  d); check("R5 log kept", d, exp_log);
      rd(A_ALOG, d); check("R5 addr log kept", d, 32'h1234_5678);
      fire(1'b1, 1'b0, 9'h002, 6'h0, 4'h0, 4'h0, 4'h0, 4'h0, '0, 1'b0, 1'b0);
      rd(A_STAT, d); check("R5 first uc no multi", d, 32'h01F);
      fire(1'b1, 1'b1, 9'h003, 6'h1, 4'h1, 4'h1, 4'h1, 4'h2, '1, 1'b0, 1'b0);
      rd(A_STAT, d); check("R5 multi uc", d, 32'h03F);
      rd(A_BLOG, d); check("R5 bank log kept", d, 32'hB);
      check("R7 irqs on", {30'd0, irq_c, irq_u}, 32'h3);

      // R2 log words are read-only
      wr(A_LOG, 32'hFFFF_FFFF);
      rd(A_LOG, d); check("R2 log write ignored", d, exp_log);

      // R7 interrupt disable keeps status
      wr(A_CTRL, 32'h3);
      check("R7 irqs masked", {30'd0, irq_c, irq_u}, 32'h0);
      rd(A_STAT, d); check("R7 status kept", d, 32'h03F);
      wr(A_CTRL, 32'h4);
      check("R7 only corr irq", {30'd0, irq_c, irq_u}, 32'h2);
      wr(A_CTRL, 32'hF);

      // R8 other values ignored, zero clears
      wr(A_STAT, 32'h0000_0005);
      rd(A_STAT, d); check("R8 partial write ignored", d, 32'h03F);
      wr(A_STAT, 32'h0);
      rd(A_STAT, d); check("R8 clear", d, 32'h0);
      check("R8 irqs dropped", {30'd0, irq_c, irq_u}, 32'h0);

      // R4 recapture after clear, with R3 qualifiers
      fire(1'b0, 1'b0, 9'h0AA, 6'h3F, 4'hF, 4'h1, 4'h2, 4'h7, 36'h3_CAFE_F00D, 1'b1, 1'b1);
      exp_log = log_word(9'h0AA, 6'h3F, 4'hF, 4'h2, 4'h1, 36'h3_CAFE_F00D);
      rd(A_STAT, d); check("R3 hit/evict flags", d, 32'h145);
      rd(A_LOG,  d); check("R4 recapture log", d, exp_log);
      rd(A_ALOG, d); check("R4 recapture addr", d, 32'hCAFE_F00D);

      // R9 injection
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d); check("R9 inject", d, 32'h37F);
      check("R9 irqs", {30'd0, irq_c, irq_u}, 32'h3);
      rd(A_LOG, d); check("R9 log untouched", d, exp_log);

      // R6 detection off ignores event completely
      wr(A_STAT, 32'h0);
      wr(A_CTRL, 32'hC);
      fire(1'b1, 1'b1, 9'h111, 6'h11, 4'h1, 4'h1, 4'h1, 4'h1, 36'h1_1111_1111, 1'b1, 1'b1);
      fire(1'b0, 1'b1, 9'h111, 6'h11, 4'h1, 4'h1, 4'h1, 4'h1, 36'h1_1111_1111, 1'b0, 1'b0);
      rd(A_STAT, d); check("R6 status", d, 32'h0);
      rd(A_LOG,  d); check("R6 log", d, exp_log);
      check("R6 irqs", {30'd0, irq_c, irq_u}, 32'h0);

      summary();
   end

endmodule